// File: doc/BRIEF.md
# Memory Region Attribute Decoder

This block classifies physical addresses by cache policy. It keeps eight programmable region descriptors. Each descriptor has a base address, a power-of-two size code and an 8-bit control code. For each address it is given, the block reports whether an enabled region covers that address. It also reports which of four policies applies: uncacheable, write-back, write-combining or write-through. Regions 0 to 6 count size in 4 KiB steps. The last region counts in 256 KiB steps, and its control codes are read with bit 0 meaning the opposite of what it means for the others.

Software reaches the descriptors through an index/data configuration port. A mode register sits at its own index and is always reachable. Bit 4 of that register opens or closes access to every descriptor and control byte. Software normally sets this bit with (old & 0x0F) | 0x10, programs the descriptors, and then writes the old value back. Lookups do not depend on the gate. An address presented with its valid strobe is captured in a register, and the result is decoded from that register one clock later.

Top module: `rad_top`

## Requirements
- R1: After reset, every descriptor byte, every control byte and the mode register read as 0. No address hits.
- R2: While mode bit 4 is clear, writes to descriptor or control indices change nothing, and reads of any index other than the mode index return 0. The mode register (index 0x10) can always be written and reads back all 8 bits.
- R3: While mode bit 4 is set, region n occupies three bytes at index 0x20+3n: address bits 31:24, then address bits 23:16, then {address bits 15:12, size code}. Its control byte is at index 0x40+n. Each of these bytes reads back exactly what was written.
- R4: A size code of 0 or 15 disables a region, whatever its base or control byte.
- R5: For regions 0 to 6, a size code s from 1 to 14 covers 4 KiB << (s-1) bytes starting at a base aligned to that size. An address hits when base <= address < base + size.
- R6: For region 7, a size code s from 1 to 14 covers 256 KiB << (s-1) bytes, matched the same way as in R5.
- R7: Output policy encoding is 0 uncacheable, 1 write-back, 2 write-combining, 3 write-through. For regions 0 to 6, control code 1 gives 0, code 8 gives 1, code 9 gives 2, and every other code gives 3.
- R8: For region 7, control code 0 gives 0, code 8 gives 2, code 9 gives 1, and every other code gives 3.
- R9: When several enabled regions cover an address, the lowest-numbered one sets the policy.
- R10: When no region covers the address, hit_o is 0 and policy_o is 1 (write-back).
- R11: The address is captured only on a clock where addr_vld_i is 1. res_vld_o is addr_vld_i delayed by one clock. hit_o and policy_o reflect the captured address from that next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_idx_i | input | 8 | Configuration register index |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Read data for the register at cfg_idx_i |
| addr_i | input | 32 | Physical address to classify |
| addr_vld_i | input | 1 | Captures addr_i on this clock |
| res_vld_o | output | 1 | Result belongs to a newly captured address |
| hit_o | output | 1 | An enabled region covers the captured address |
| policy_o | output | 2 | Cache policy code for the captured address |

## Verification
The bench sweeps all sixteen size codes on every region, probing the first and last byte and both neighbours just outside each range. A shift that is off by one, or that forgets the 64x unit of region 7, would then move a hit across a boundary. All 256 control codes are applied to both a fine region and the coarse region. A swapped table or a missing default would show up as the wrong policy for codes 8, 9, 0/1 or a stray value. Overlapping regions are peeled away one by one to expose a priority chain that favours the wrong end. The gate is exercised with writes and reads issued while it is closed, and a leaky gate would corrupt a descriptor or leak its contents.

// File: rtl/rad_pkg.sv
package rad_pkg;

  typedef enum logic [1:0] {
    POL_UC = 2'd0,
    POL_WB = 2'd1,
    POL_WC = 2'd2,
    POL_WT = 2'd3
  } policy_e;

  localparam int unsigned SIZE_W = 4;
  localparam int unsigned BYTE_W = 8;
  localparam logic [SIZE_W-1:0] SIZE_OFF  = '0;
  localparam logic [SIZE_W-1:0] SIZE_RSVD = '1;

  // Fine regions: bit 0 of the code disables caching.
  function automatic policy_e fine_policy(input logic [BYTE_W-1:0] code);
    case (code)
      8'd1:    return POL_UC;
      8'd8:    return POL_WB;
      8'd9:    return POL_WC;
      default: return POL_WT;
    endcase
  endfunction

  // Coarse region: bit 0 of the code enables caching.
  function automatic policy_e coarse_policy(input logic [BYTE_W-1:0] code);
    case (code)
      8'd0:    return POL_UC;
      8'd8:    return POL_WC;
      8'd9:    return POL_WB;
      default: return POL_WT;
    endcase
  endfunction

endpackage

// File: rtl/rad_cfg_regs.sv
module rad_cfg_regs import rad_pkg::*; #(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned IDX_W       = 8,
  parameter int unsigned MODE_IDX    = 16,
  parameter int unsigned ADDR_BASE   = 32,
  parameter int unsigned CTL_BASE    = 64,
  parameter int unsigned GATE_BIT    = 4,
  localparam int unsigned DESC_BYTES = 3,
  localparam int unsigned DESC_W     = DESC_BYTES * BYTE_W
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic [IDX_W-1:0]                         cfg_idx_i,
  input  logic                                     cfg_we_i,
  input  logic [BYTE_W-1:0]                        cfg_wdata_i,
  output logic [BYTE_W-1:0]                        cfg_rdata_o,
  output logic                                     map_en_o,
  output logic [NUM_REGIONS-1:0][DESC_W-1:0]       desc_o,
  output logic [NUM_REGIONS-1:0][BYTE_W-1:0]       ctl_o
);

  logic [BYTE_W-1:0] mode_q, mode_d;
  logic              mode_en;
  logic [NUM_REGIONS-1:0][DESC_BYTES-1:0] desc_we;
  logic [NUM_REGIONS-1:0]                 ctl_we;
  logic [NUM_REGIONS-1:0][DESC_W-1:0]     desc_q;
  logic [NUM_REGIONS-1:0][BYTE_W-1:0]     ctl_q;

  assign map_en_o = mode_q[GATE_BIT];

  // Write decode
  always_comb begin
    mode_en = cfg_we_i && (cfg_idx_i == IDX_W'(MODE_IDX));
    mode_d  = cfg_wdata_i;
    for (int n = 0; n < NUM_REGIONS; n++) begin
      for (int k = 0; k < DESC_BYTES; k++) begin
        desc_we[n][k] = cfg_we_i && map_en_o &&
                        (cfg_idx_i == IDX_W'(ADDR_BASE + DESC_BYTES*n + k));
      end
      ctl_we[n] = cfg_we_i && map_en_o && (cfg_idx_i == IDX_W'(CTL_BASE + n));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end

  // Byte k = 0 is the most significant address byte.
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    for (genvar b = 0; b < DESC_BYTES; b++) begin : g_byte
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            desc_q[g][BYTE_W*(DESC_BYTES-1-b) +: BYTE_W] <= '0;
        else if (desc_we[g][b]) desc_q[g][BYTE_W*(DESC_BYTES-1-b) +: BYTE_W] <= cfg_wdata_i;
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        ctl_q[g] <= '0;
      else if (ctl_we[g]) ctl_q[g] <= cfg_wdata_i;
    end
  end

  // Read mux: descriptors are visible only while the gate is open.
  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_idx_i == IDX_W'(MODE_IDX)) cfg_rdata_o = mode_q;
    if (map_en_o) begin
      for (int n = 0; n < NUM_REGIONS; n++) begin
        for (int k = 0; k < DESC_BYTES; k++) begin
          if (cfg_idx_i == IDX_W'(ADDR_BASE + DESC_BYTES*n + k))
            cfg_rdata_o = desc_q[n][BYTE_W*(DESC_BYTES-1-k) +: BYTE_W];
        end
        if (cfg_idx_i == IDX_W'(CTL_BASE + n)) cfg_rdata_o = ctl_q[n];
      end
    end
  end

  assign desc_o = desc_q;
  assign ctl_o  = ctl_q;

endmodule

// File: rtl/rad_region_match.sv
module rad_region_match import rad_pkg::*; #(
  parameter int unsigned PAGE_W       = 20,
  parameter bit          COARSE       = 1'b0,
  parameter int unsigned COARSE_SHIFT = 6,
  localparam int unsigned DESC_W      = PAGE_W + SIZE_W,
  localparam int unsigned SHIFT_OFS   = COARSE ? COARSE_SHIFT : 0,
  localparam int unsigned IGN_W       = $clog2(PAGE_W + 1) + 1
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [DESC_W-1:0] desc_i,
  input  logic [BYTE_W-1:0] ctl_i,
  output logic              hit_o,
  output policy_e           policy_o
);

  logic [SIZE_W-1:0] size_code;
  logic [PAGE_W-1:0] base_page;
  logic [IGN_W-1:0]  ign_bits;
  logic [PAGE_W-1:0] keep_mask;
  logic              enabled;

  assign size_code = desc_i[SIZE_W-1:0];
  assign base_page = desc_i[DESC_W-1:SIZE_W];

  always_comb begin
    enabled   = (size_code != SIZE_OFF) && (size_code != SIZE_RSVD);
    ign_bits  = IGN_W'(size_code) - IGN_W'(1) + IGN_W'(SHIFT_OFS);
    keep_mask = {PAGE_W{1'b1}} << ign_bits;
    hit_o     = enabled && (((page_i ^ base_page) & keep_mask) == '0);
  end

  if (COARSE) begin : g_coarse
    assign policy_o = coarse_policy(ctl_i);
  end else begin : g_fine
    assign policy_o = fine_policy(ctl_i);
  end

endmodule

// File: rtl/rad_prio_sel.sv
module rad_prio_sel import rad_pkg::*; #(
  parameter int unsigned NUM_REGIONS = 8
) (
  input  logic    [NUM_REGIONS-1:0] hit_vec_i,
  input  policy_e [NUM_REGIONS-1:0] pol_vec_i,
  output logic                      hit_o,
  output policy_e                   policy_o
);

  // Scan from the top down so the lowest hitting index is written last.
  always_comb begin
    hit_o    = 1'b0;
    policy_o = POL_WB;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit_vec_i[i]) begin
        hit_o    = 1'b1;
        policy_o = pol_vec_i[i];
      end
    end
  end

endmodule

// File: rtl/rad_top.sv
module rad_top import rad_pkg::*; #(
  parameter int unsigned NUM_REGIONS  = 8,
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned PAGE_SHIFT   = 12,
  parameter int unsigned COARSE_SHIFT = 6,
  parameter int unsigned IDX_W        = 8,
  parameter int unsigned MODE_IDX     = 16,
  parameter int unsigned ADDR_BASE    = 32,
  parameter int unsigned CTL_BASE     = 64,
  parameter int unsigned GATE_BIT     = 4,
  localparam int unsigned PAGE_W      = ADDR_W - PAGE_SHIFT,
  localparam int unsigned DESC_W      = PAGE_W + SIZE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_vld_i,
  output logic              res_vld_o,
  output logic              hit_o,
  output logic [1:0]        policy_o
);

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  // Configuration register file
  logic                               map_en;
  logic [NUM_REGIONS-1:0][DESC_W-1:0] desc_w;
  logic [NUM_REGIONS-1:0][BYTE_W-1:0] ctl_w;

  rad_cfg_regs #(
    .NUM_REGIONS (NUM_REGIONS),
    .IDX_W       (IDX_W),
    .MODE_IDX    (MODE_IDX),
    .ADDR_BASE   (ADDR_BASE),
    .CTL_BASE    (CTL_BASE),
    .GATE_BIT    (GATE_BIT)
  ) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_q_n),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .map_en_o    (map_en),
    .desc_o      (desc_w),
    .ctl_o       (ctl_w)
  );

  // Address capture
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              vld_q;

  always_comb begin
    addr_d = addr_vld_i ? addr_i : addr_q;
  end

  always_ff @(posedge clk_i or negedge rst_q_n) begin
    if (!rst_q_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      vld_q  <= addr_vld_i;
    end
  end

  // Per-region match; the last region uses the coarse unit and code table
  logic    [NUM_REGIONS-1:0] hit_vec;
  policy_e [NUM_REGIONS-1:0] pol_vec;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    rad_region_match #(
      .PAGE_W       (PAGE_W),
      .COARSE       (g == NUM_REGIONS - 1),
      .COARSE_SHIFT (COARSE_SHIFT)
    ) match_i (
      .page_i   (addr_q[ADDR_W-1:PAGE_SHIFT]),
      .desc_i   (desc_w[g]),
      .ctl_i    (ctl_w[g]),
      .hit_o    (hit_vec[g]),
      .policy_o (pol_vec[g])
    );
  end

  policy_e pol_sel;

  rad_prio_sel #(
    .NUM_REGIONS (NUM_REGIONS)
  ) sel_i (
    .hit_vec_i (hit_vec),
    .pol_vec_i (pol_vec),
    .hit_o     (hit_o),
    .policy_o  (pol_sel)
  );

  assign policy_o  = pol_sel;
  assign res_vld_o = vld_q;

endmodule

// File: rtl/rad_checker.sv
module rad_checker import rad_pkg::*; #(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned DESC_W      = 24,
  parameter int unsigned IDX_W       = 8,
  parameter int unsigned MODE_IDX    = 16
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               rst_q_n,
  input logic [IDX_W-1:0]                   cfg_idx_i,
  input logic                               cfg_we_i,
  input logic [7:0]                         cfg_rdata_o,
  input logic                               map_en,
  input logic [NUM_REGIONS-1:0][DESC_W-1:0] desc_w,
  input logic [NUM_REGIONS-1:0][7:0]        ctl_w,
  input logic                               addr_vld_i,
  input logic                               res_vld_o,
  input logic                               hit_o,
  input logic [1:0]                         policy_o
);

  logic all_off;
  always_comb begin
    all_off = 1'b1;
    for (int n = 0; n < NUM_REGIONS; n++) begin
      if (desc_w[n][SIZE_W-1:0] != SIZE_OFF && desc_w[n][SIZE_W-1:0] != SIZE_RSVD)
        all_off = 1'b0;
    end
  end

  AST_VLD_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_q_n)
    addr_vld_i |=> res_vld_o); // R11

  AST_VLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_q_n)
    !addr_vld_i |=> !res_vld_o); // R11

  AST_MISS_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_q_n)
    !hit_o |-> policy_o == 2'd1); // R10

  AST_GATED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_q_n)
    (cfg_we_i && !map_en) |=> ($stable(desc_w) && $stable(ctl_w))); // R2

  AST_GATED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_q_n)
    (!map_en && cfg_idx_i != IDX_W'(MODE_IDX)) |-> cfg_rdata_o == 8'd0); // R2

  AST_ALL_OFF_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_q_n)
    all_off |-> !hit_o); // R4

endmodule

bind rad_top rad_checker #(
  .NUM_REGIONS (NUM_REGIONS),
  .DESC_W      (DESC_W),
  .IDX_W       (IDX_W),
  .MODE_IDX    (MODE_IDX)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rst_q_n     (rst_q_n),
  .cfg_idx_i   (cfg_idx_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_rdata_o (cfg_rdata_o),
  .map_en      (map_en),
  .desc_w      (desc_w),
  .ctl_w       (ctl_w),
  .addr_vld_i  (addr_vld_i),
  .res_vld_o   (res_vld_o),
  .hit_o       (hit_o),
  .policy_o    (policy_o)
);

// File: tb/rad_top_tb_top.sv
module rad_top_tb_top;

  localparam int MODE_IDX  = 16;
  localparam int ADDR_BASE = 32;
  localparam int CTL_BASE  = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  cfg_idx_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  cfg_rdata_o;
  logic [31:0] addr_i = '0;
  logic        addr_vld_i = 1'b0;
  logic        res_vld_o;
  logic        hit_o;
  logic [1:0]  policy_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // Bench-side copy of what was programmed
  logic [31:0] m_base [8];
  int          m_size [8];
  int          m_ctl  [8];

  always #2 clk_i = ~clk_i;

  rad_top dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .addr_i      (addr_i),
    .addr_vld_i  (addr_vld_i),
    .res_vld_o   (res_vld_o),
    .hit_o       (hit_o),
    .policy_o    (policy_o)
  );

  function automatic longint unsigned region_bytes(int n, int s);
    longint unsigned unit;
    if (s == 0 || s == 15) return 0;
    unit = (n == 7) ? 64'd262144 : 64'd4096;
    return unit << (s - 1);
  endfunction

  function automatic int exp_pol(int n, int code);
    if (n < 7) begin
      if (code == 1) return 0;
      if (code == 8) return 1;
      if (code == 9) return 2;
      return 3;
    end
    if (code == 0) return 0;
    if (code == 8) return 2;
    if (code == 9) return 1;
    return 3;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(int idx, int data);
    @(negedge clk_i);
    cfg_idx_i   = 8'(idx);
    cfg_wdata_i = 8'(data);
    cfg_we_i    = 1'b1;
    @(negedge clk_i);
    cfg_we_i    = 1'b0;
  endtask

  task automatic cfg_read(int idx, output logic [7:0] val);
    @(negedge clk_i);
    cfg_idx_i = 8'(idx);
    #1;
    val = cfg_rdata_o;
  endtask

  task automatic program_region(int n, logic [31:0] base, int s, int ctl);
    cfg_write(ADDR_BASE + 3*n,     base[31:24]);
    cfg_write(ADDR_BASE + 3*n + 1, base[23:16]);
    cfg_write(ADDR_BASE + 3*n + 2, {base[15:12], 4'(s)});
    cfg_write(CTL_BASE + n, ctl);
    m_base[n] = base;
    m_size[n] = s;
    m_ctl[n]  = ctl;
  endtask

  task automatic probe(string req, logic [31:0] a);
    longint unsigned sz, lo, av;
    int  e_pol = 1;
    bit  e_hit = 1'b0;
    for (int n = 7; n >= 0; n--) begin
      sz = region_bytes(n, m_size[n]);
      lo = {32'd0, m_base[n]};
      av = {32'd0, a};
      if (sz != 0 && av >= lo && av < lo + sz) begin
        e_hit = 1'b1;
        e_pol = exp_pol(n, m_ctl[n]);
      end
    end
    @(negedge clk_i);
    addr_i     = a;
    addr_vld_i = 1'b1;
    @(negedge clk_i);
    addr_vld_i = 1'b0;
    check({req, " hit"}, 32'(hit_o), 32'(e_hit));
    check({req, " policy"}, 32'(policy_o), 32'(e_pol));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    for (int n = 0; n < 8; n++) begin
      m_base[n] = '0; m_size[n] = 0; m_ctl[n] = 0;
    end
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R1: reset state (gate opened only to look at the descriptors)
    cfg_read(MODE_IDX, rd);
    check("R1 mode reset", 32'(rd), 32'd0);
    probe("R1 no hit after reset", 32'h0000_0000);
    probe("R10 miss default", 32'hFFFF_F000);

    // R2: writes while closed are dropped
    cfg_write(ADDR_BASE, 8'hAA);
    cfg_write(ADDR_BASE + 23, 8'h5B);
    cfg_write(CTL_BASE + 7, 8'h55);
    cfg_write(MODE_IDX, (0 & 8'h0F) | 8'h10);
    for (int i = 0; i < 24; i++) begin
      cfg_read(ADDR_BASE + i, rd);
      check("R1 R2 descriptor byte after closed write", 32'(rd), 32'd0);
    end
    for (int n = 0; n < 8; n++) begin
      cfg_read(CTL_BASE + n, rd);
      check("R1 R2 control byte after closed write", 32'(rd), 32'd0);
    end

    // R3: readback with the gate open
    program_region(2, 32'h1234_5000, 3, 8'h18);
    cfg_read(ADDR_BASE + 6, rd); check("R3 byte 0", 32'(rd), 32'h12);
    cfg_read(ADDR_BASE + 7, rd); check("R3 byte 1", 32'(rd), 32'h34);
    cfg_read(ADDR_BASE + 8, rd); check("R3 byte 2", 32'(rd), 32'h53);
    cfg_read(CTL_BASE + 2, rd);  check("R3 control", 32'(rd), 32'h18);

    // R2: mode register full width, reads closed
    cfg_write(MODE_IDX, 8'h0A);
    cfg_read(MODE_IDX, rd);      check("R2 mode readback", 32'(rd), 32'h0A);
    cfg_read(ADDR_BASE + 6, rd); check("R2 closed read", 32'(rd), 32'h00);
    cfg_read(CTL_BASE + 2, rd);  check("R2 closed ctl read", 32'(rd), 32'h00);
    cfg_write(CTL_BASE + 2, 8'h01);
    cfg_write(MODE_IDX, (8'h0A & 8'h0F) | 8'h10);
    cfg_read(MODE_IDX, rd);      check("R2 mode reopen", 32'(rd), 32'h1A);
    cfg_read(CTL_BASE + 2, rd);  check("R2 closed write dropped", 32'(rd), 32'h18);
    program_region(2, 32'h0, 0, 0);

    // R4 R5 R6: size sweep per region
    for (int n = 0; n < 8; n++) begin
      for (int s = 0; s < 16; s++) begin
        longint unsigned raw;
        logic [31:0] b;
        raw = ((n == 7) ? 64'd262144 : 64'd4096) << ((s == 0) ? 0 : s - 1);
        b = (s == 0 || s == 15) ? 32'h0ABC_D000 : 32'(raw * longint'(n + 1));
        program_region(n, b, s, (n == 7) ? 8 : 9);
        probe((n == 7) ? "R6 R4 base" : "R5 R4 base", b);
        probe((n == 7) ? "R6 last byte" : "R5 last byte", b + 32'(raw - 1));
        probe((n == 7) ? "R6 one past" : "R5 one past", b + 32'(raw));
        probe((n == 7) ? "R6 below base" : "R5 below base", b - 32'd1);
        probe((n == 7) ? "R6 middle" : "R5 middle", b + 32'(raw / 2));
      end
      program_region(n, 32'h0, 0, 0);
    end

    // R7: every control code on a fine region
    program_region(0, 32'h0, 1, 0);
    for (int c = 0; c < 256; c++) begin
      cfg_write(CTL_BASE, c); m_ctl[0] = c;
      probe("R7 fine code", 32'h0000_0800);
    end
    program_region(0, 32'h0, 0, 0);

    // R8: every control code on the coarse region
    program_region(7, 32'h0, 1, 0);
    for (int c = 0; c < 256; c++) begin
      cfg_write(CTL_BASE + 7, c); m_ctl[7] = c;
      probe("R8 coarse code", 32'h0002_0000);
    end

    // R9: overlapping regions peeled from the bottom
    for (int n = 0; n < 7; n++) begin
      int codes [4] = '{1, 8, 9, 24};
      program_region(n, 32'h0, 5, codes[n % 4]);
    end
    program_region(7, 32'h0, 1, 0);
    probe("R9 only coarse covers", 32'h0003_0000);
    for (int n = 0; n < 8; n++) begin
      probe("R9 lowest wins", 32'h0000_1000);
      program_region(n, 32'h0, 0, m_ctl[n]);
    end
    probe("R10 all peeled", 32'h0000_1000);

    // R11: valid pipeline and address hold
    program_region(3, 32'h0040_0000, 2, 8'd1);
    @(negedge clk_i);
    addr_i = 32'h0040_1000; addr_vld_i = 1'b1;
    @(negedge clk_i);
    check("R11 valid follows", 32'(res_vld_o), 32'd1);
    check("R11 hit", 32'(hit_o), 32'd1);
    addr_vld_i = 1'b0; addr_i = 32'h0900_0000;
    @(negedge clk_i);
    check("R11 valid drops", 32'(res_vld_o), 32'd0);
    check("R11 address held", 32'(hit_o), 32'd1);
    check("R11 policy held", 32'(policy_o), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule